// File: doc/BRIEF.md
# Parallel ADC Host Controller

This block runs one complete conversion cycle of a simultaneous-sampling converter that has a parallel bus. A start request first latches a channel-enable mask and the timing settings. The controller writes the mask into the converter's configuration register with a chip-select/write strobe. It then holds the convert-start line low for a set acquisition window and releases it, which begins conversion.

While the conversion runs, every falling edge on the end-of-conversion line marks one result that is ready. The controller counts these edges and reads each result with a chip-select/read strobe. It sends the result out on a valid/ready stream, tagged with its channel number. The cycle ends once the end-of-last-conversion line has been seen low and no counted result is still unread. A watchdog on the waiting state ends a cycle that stalls and reports it as an error. The converter's outputs are taken to be synchronous to `clk`.

Top module: `adc_host_ctrl`

## Requirements
- R1: During and after reset, with no start accepted, `bus_cs_n`, `bus_wr_n`, `bus_rd_n` and `bus_convst_n` are high, and `busy`, `err` and `m_valid` are low.
- R2: A `start` sampled while idle latches `cfg_mask`, `cfg_acq`, `cfg_strobe` and `cfg_timeout`. In the next cycle `bus_cs_n` and `bus_wr_n` go low, with `bus_doe` high and `bus_dout` equal to the mask (bit i enables channel i). They stay low for max(`cfg_strobe`,1) cycles. Then `bus_wr_n` rises for one cycle while `bus_cs_n` stays low and the mask is still driven.
- R3: `bus_convst_n` falls only directly after a configuration write, with `bus_cs_n` high. It stays low for exactly max(`cfg_acq`,2) cycles, then rises to start conversion.
- R4: Each falling edge of `eoc_n` seen during the conversion leads to exactly one read, and up to 8 such edges may wait unread. A read holds `bus_cs_n` and `bus_rd_n` low, with `bus_convst_n` and `bus_wr_n` high, for max(`cfg_strobe`,1) cycles. It captures `bus_din` in the last of those cycles.
- R5: Each captured value appears on `m_data`. `m_chan` carries the enabled channel numbers of the latched mask in ascending order.
- R6: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_data` and `m_chan` hold steady. No read strobe is issued while a result is waiting on the stream.
- R7: `bus_convst_n` stays high from the start of conversion until the cycle ends.
- R8: Once `eolc_n` has been seen low and no counted edge is unread, the controller returns to idle with no error. By then every result has been read and delivered.
- R9: If the controller waits max(`cfg_timeout`,1) consecutive cycles with no unread edge and no `eolc_n` seen, `err` is high for one cycle in the following cycle and `busy` drops.
- R10: A `start` or a change of `cfg_mask` while `busy` is high has no effect: no extra configuration write and no change of tags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request one conversion cycle (sampled when idle) |
| cfg_mask | input | 8 | Channel-enable mask, bit i = channel i |
| cfg_acq | input | 16 | Acquisition window in clocks (minimum 2) |
| cfg_strobe | input | 4 | Write/read strobe width in clocks (minimum 1) |
| cfg_timeout | input | 20 | Wait-state limit in clocks (minimum 1) |
| busy | output | 1 | A cycle is in progress |
| err | output | 1 | One-cycle timeout pulse |
| bus_cs_n | output | 1 | Converter chip select, active low |
| bus_wr_n | output | 1 | Configuration write strobe, active low |
| bus_rd_n | output | 1 | Result read strobe, active low |
| bus_convst_n | output | 1 | Convert start: low acquires, rising edge converts |
| bus_dout | output | 8 | Mask driven onto the bus |
| bus_doe | output | 1 | Bus output enable for `bus_dout` |
| bus_din | input | 14 | Result read from the bus |
| eoc_n | input | 1 | End-of-conversion pulse, one per result |
| eolc_n | input | 1 | End-of-last-conversion, low when the final result is ready |
| m_valid | output | 1 | Stream result valid |
| m_ready | input | 1 | Stream consumer ready |
| m_data | output | 14 | Stream result value |
| m_chan | output | 3 | Stream channel tag |

## Verification
The strobes switch in the cycle after the state that owns them is entered. The write strobe falls one cycle after `start` is sampled. `bus_convst_n` falls the cycle after the write strobe rises. A read begins two edges after an `eoc_n` fall is presented: one edge counts the fall, the next enters the read. The bench's converter model takes the widths of the write, acquisition and read strobes from counters at each rising strobe edge, so these checks do not rely on exact start latencies. The timeout error is expected in exactly the cycle whose index, counted from the first high cycle of `bus_convst_n`, equals the effective limit. Stream data, tags and handshakes are compared with a queue on every negative edge, using the ready value that applies at the next rising edge.

// File: rtl/adc_host_pkg.sv
// Shared types for the parallel ADC host controller.
package adc_host_pkg;

    // Controller sequencing states.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_WRS  = 3'd1,   // configuration write strobe low
        ST_WRH  = 3'd2,   // write strobe released, chip select held
        ST_ACQ  = 3'd3,   // convert-start low, acquisition
        ST_WAIT = 3'd4,   // conversion running, waiting for a result
        ST_RD   = 3'd5,   // read strobe low
        ST_PUSH = 3'd6    // result offered on the stream
    } host_st_e;

endpackage

// File: rtl/adc_tag_seq.sv
// Channel tag sequencer.
// Holds the mask captured at cycle start and steps through its set bits
// in ascending order, one step per delivered result, wrapping to the lowest.
// Assumes load and advance are never asserted together.
module adc_tag_seq #(
    parameter int NCH  = 8,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [NCH-1:0]  mask_in,
    input  logic            advance,
    output logic [CH_W-1:0] chan
);

    logic [NCH-1:0]  mask_q;
    logic [CH_W-1:0] chan_q;
    logic [CH_W-1:0] low_in;
    logic [CH_W-1:0] low_q;
    logic [CH_W-1:0] next_q;

    // Lowest enabled channel of the incoming mask.
    always_comb begin
        low_in = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (mask_in[i]) low_in = CH_W'(i);
        end
    end

    // Next enabled channel above the current one, else the lowest.
    always_comb begin
        logic found;
        low_q = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (mask_q[i]) low_q = CH_W'(i);
        end
        next_q = low_q;
        found  = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (!found && mask_q[i] && (i > int'(chan_q))) begin
                next_q = CH_W'(i);
                found  = 1'b1;
            end
        end
    end

    // Tag and mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            chan_q <= '0;
        end else if (load) begin
            mask_q <= mask_in;
            chan_q <= low_in;
        end else if (advance) begin
            chan_q <= next_q;
        end
    end

    assign chan = chan_q;

    // The tag always names a channel enabled in the captured mask.
    p_tag_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|mask_q) |-> mask_q[chan_q]);

endmodule

// File: rtl/adc_evt_track.sv
// Conversion event tracker.
// Counts falling edges of the end-of-conversion line that are not yet read,
// and remembers that end-of-last-conversion was seen, while armed.
// Assumes the converter inputs are synchronous to clk.
module adc_evt_track #(
    parameter int NCH    = 8,
    localparam int PEND_W = $clog2(NCH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic armed,
    input  logic eoc_n,
    input  logic eolc_n,
    input  logic take,
    output logic pending,
    output logic last_seen
);

    logic              eoc_prev;
    logic [PEND_W-1:0] pend_q;
    logic              last_q;
    logic              fall;

    assign fall = armed && eoc_prev && !eoc_n;

    // Previous end-of-conversion level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) eoc_prev <= 1'b1;
        else        eoc_prev <= eoc_n;
    end

    // Unread result counter and last-result flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pend_q <= '0;
            last_q <= 1'b0;
        end else begin
            pend_q <= pend_q + PEND_W'(fall) - PEND_W'(take);
            if (armed && !eolc_n) last_q <= 1'b1;
        end
    end

    assign pending   = (pend_q != '0);
    assign last_seen = last_q;

    p_pend_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q <= PEND_W'(NCH));
    p_take_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (pend_q != '0));

endmodule

// File: rtl/adc_host_ctrl.sv
// Parallel ADC host controller (top).
// Per start request: writes the channel mask, runs the acquisition window on
// convert-start, reads one result per end-of-conversion edge and streams it
// with a channel tag, finishing on end-of-last-conversion or a wait timeout.
// Bus strobes are decoded from the state register; converter inputs are
// assumed synchronous to clk.
module adc_host_ctrl
    import adc_host_pkg::*;
#(
    parameter int DATA_W = 14,
    parameter int NCH    = 8,
    parameter int ACQ_W  = 16,
    parameter int STB_W  = 4,
    parameter int TO_W   = 20,
    localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int CNT_W = (ACQ_W > STB_W) ? ACQ_W : STB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [NCH-1:0]    cfg_mask,
    input  logic [ACQ_W-1:0]  cfg_acq,
    input  logic [STB_W-1:0]  cfg_strobe,
    input  logic [TO_W-1:0]   cfg_timeout,
    output logic              busy,
    output logic              err,
    output logic              bus_cs_n,
    output logic              bus_wr_n,
    output logic              bus_rd_n,
    output logic              bus_convst_n,
    output logic [NCH-1:0]    bus_dout,
    output logic              bus_doe,
    input  logic [DATA_W-1:0] bus_din,
    input  logic              eoc_n,
    input  logic              eolc_n,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [DATA_W-1:0] m_data,
    output logic [CH_W-1:0]   m_chan
);

    host_st_e          state;
    logic [CNT_W-1:0]  cnt;
    logic [TO_W-1:0]   to_cnt;
    logic [NCH-1:0]    mask_q;
    logic [ACQ_W-1:0]  acq_q;
    logic [STB_W-1:0]  stb_q;
    logic [TO_W-1:0]   to_q;
    logic [DATA_W-1:0] data_q;
    logic              err_q;

    logic              accept;
    logic              armed;
    logic              take;
    logic              pending;
    logic              last_seen;
    logic              deliver;
    logic [CNT_W-1:0]  stb_load;
    logic [CNT_W-1:0]  acq_load;
    logic [TO_W-1:0]   to_last;

    assign accept  = (state == ST_IDLE) && start;
    assign armed   = (state == ST_WAIT) || (state == ST_RD) || (state == ST_PUSH);
    assign take    = (state == ST_WAIT) && pending;
    assign deliver = (state == ST_PUSH) && m_ready;

    // Effective counter loads with the minimum widths applied.
    always_comb begin
        stb_load = (stb_q == '0) ? '0 : CNT_W'(stb_q - STB_W'(1));
        acq_load = (acq_q < ACQ_W'(2)) ? CNT_W'(1) : CNT_W'(acq_q - ACQ_W'(1));
        to_last  = (to_q == '0) ? '0 : to_q - TO_W'(1);
    end

    // Sequencing state machine with its strobe and wait counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            to_cnt <= '0;
            mask_q <= '0;
            acq_q  <= '0;
            stb_q  <= '0;
            to_q   <= '0;
            data_q <= '0;
            err_q  <= 1'b0;
        end else begin
            err_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        mask_q <= cfg_mask;
                        acq_q  <= cfg_acq;
                        stb_q  <= cfg_strobe;
                        to_q   <= cfg_timeout;
                        cnt    <= (cfg_strobe == '0) ? '0
                                  : CNT_W'(cfg_strobe - STB_W'(1));
                        state  <= ST_WRS;
                    end
                end
                ST_WRS: begin
                    if (cnt == '0) state <= ST_WRH;
                    else           cnt   <= cnt - CNT_W'(1);
                end
                ST_WRH: begin
                    cnt   <= acq_load;
                    state <= ST_ACQ;
                end
                ST_ACQ: begin
                    if (cnt == '0) begin
                        to_cnt <= '0;
                        state  <= ST_WAIT;
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                ST_WAIT: begin
                    if (pending) begin
                        cnt   <= stb_load;
                        state <= ST_RD;
                    end else if (last_seen) begin
                        state <= ST_IDLE;
                    end else if (to_cnt == to_last) begin
                        err_q <= 1'b1;
                        state <= ST_IDLE;
                    end else begin
                        to_cnt <= to_cnt + TO_W'(1);
                    end
                end
                ST_RD: begin
                    if (cnt == '0) begin
                        data_q <= bus_din;
                        state  <= ST_PUSH;
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                ST_PUSH: begin
                    if (m_ready) begin
                        to_cnt <= '0;
                        state  <= ST_WAIT;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    adc_evt_track #(.NCH(NCH)) u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .armed    (armed),
        .eoc_n    (eoc_n),
        .eolc_n   (eolc_n),
        .take     (take),
        .pending  (pending),
        .last_seen(last_seen)
    );

    adc_tag_seq #(.NCH(NCH)) u_tag (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .mask_in(cfg_mask),
        .advance(deliver),
        .chan   (m_chan)
    );

    // Bus strobes and stream outputs decoded from the state register.
    always_comb begin
        bus_cs_n     = !((state == ST_WRS) || (state == ST_WRH) || (state == ST_RD));
        bus_wr_n     = (state != ST_WRS);
        bus_rd_n     = (state != ST_RD);
        bus_convst_n = (state != ST_ACQ);
        bus_doe      = (state == ST_WRS) || (state == ST_WRH);
        bus_dout     = mask_q;
        m_valid      = (state == ST_PUSH);
        m_data       = data_q;
        busy         = (state != ST_IDLE);
        err          = err_q;
    end

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_chan)));
    p_noread_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> bus_rd_n);
    p_convst_after_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_convst_n) |-> ($past(!bus_cs_n && bus_doe && bus_wr_n) && bus_cs_n));
    p_convst_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd_n || m_valid) |-> bus_convst_n);
    p_err_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && $past(state == ST_WAIT)));

endmodule

// File: tb/adc_host_ctrl_test.sv
// Bench: a behavioural converter model plus queue scoreboard, checked every clock.
module adc_host_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  cfg_mask = '0;
    logic [15:0] cfg_acq = '0;
    logic [3:0]  cfg_strobe = '0;
    logic [19:0] cfg_timeout = '0;
    logic        busy, err, bus_cs_n, bus_wr_n, bus_rd_n, bus_convst_n, bus_doe;
    logic [7:0]  bus_dout;
    logic [13:0] bus_din = '0;
    logic        eoc_n = 1'b1;
    logic        eolc_n = 1'b1;
    logic        m_valid;
    logic        m_ready = 1'b1;
    logic [13:0] m_data;
    logic [2:0]  m_chan;

    always #2 clk = ~clk;

    adc_host_ctrl uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_mask(cfg_mask),
        .cfg_acq(cfg_acq), .cfg_strobe(cfg_strobe), .cfg_timeout(cfg_timeout),
        .busy(busy), .err(err), .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n),
        .bus_rd_n(bus_rd_n), .bus_convst_n(bus_convst_n), .bus_dout(bus_dout),
        .bus_doe(bus_doe), .bus_din(bus_din), .eoc_n(eoc_n), .eolc_n(eolc_n),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_chan(m_chan)
    );

    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Test settings seen by the model.
    logic [7:0] exp_mask = '0;
    int  exp_stb = 1, exp_acq = 2, exp_to = 1;
    int  ready_mode = 0;
    bit  silent = 1'b0;

    // Model state.
    int  cyc = 0, k = 0;
    int  wr_w = 0, rd_w = 0, cv_w = 0;
    logic p_wr = 1'b1, p_rd = 1'b1, p_cv = 1'b1;
    bit  in_conv = 1'b0, wrote = 1'b0;
    int  n_res = 0, produced = 0, rd_idx = 0, run_id = 0;
    int  n_cfg_writes = 0, err_pulses = 0;
    logic [7:0]  latched = '0;
    int  ch_list[8];
    logic [13:0] res_val[8];
    logic [13:0] q_data[$];
    int  q_chan[$];
    bit  p_valid = 1'b0, p_ready = 1'b1;
    logic [13:0] p_data = '0;
    logic [2:0]  p_chan = '0;

    // Converter model, protocol checks and stream scoreboard.
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            // R2 configuration write
            if (!bus_wr_n) begin
                wr_w++;
                chk(!bus_cs_n && bus_doe && bus_dout == exp_mask, "R2 write bus", int'(bus_dout), int'(exp_mask));
            end
            if (!p_wr && bus_wr_n) begin
                chk(wr_w == exp_stb, "R2 write width", wr_w, exp_stb);
                chk(!bus_cs_n && bus_doe && bus_dout == exp_mask, "R2 latch", int'(bus_dout), int'(exp_mask));
                latched = bus_dout;
                n_cfg_writes++;
                wrote = 1'b1;
                wr_w = 0;
            end
            // R3 acquisition
            if (!bus_convst_n) begin
                cv_w++;
                if (p_cv) begin
                    chk(wrote, "R3 convst after write", int'(wrote), 1);
                    eolc_n = 1'b1;
                end
                chk(bus_cs_n, "R3 cs high in acq", int'(bus_cs_n), 1);
            end
            if (!p_cv && bus_convst_n) begin
                chk(cv_w == exp_acq, "R3 acq width", cv_w, exp_acq);
                cv_w = 0; wrote = 1'b0; in_conv = 1'b1; k = 0;
                n_res = 0; produced = 0; rd_idx = 0; run_id++;
                for (int i = 0; i < 8; i++) begin
                    if (latched[i]) begin
                        ch_list[n_res] = i;
                        res_val[n_res] = 14'((run_id * 131 + i * 977 + n_res * 53 + 3) % 16384);
                        n_res++;
                    end
                end
            end else if (in_conv) begin
                k++;
            end
            // converter result timing: first at 6, then every 3 cycles
            eoc_n = 1'b1;
            if (in_conv && !silent && produced < n_res && k == 6 + 3 * produced) begin
                eoc_n = 1'b0;
                q_data.push_back(res_val[produced]);
                q_chan.push_back(ch_list[produced]);
                produced++;
                if (produced == n_res) eolc_n = 1'b0;
            end
            // R4 reads
            if (!bus_rd_n) begin
                rd_w++;
                chk(!bus_cs_n && bus_convst_n && bus_wr_n, "R4 read strobe", int'(bus_cs_n), 0);
            end
            if (!p_rd && bus_rd_n) begin
                chk(rd_w == exp_stb, "R4 read width", rd_w, exp_stb);
                chk(rd_idx < produced, "R4 read has result", rd_idx, produced);
                rd_idx++;
                rd_w = 0;
            end
            bus_din = (rd_idx < 8) ? res_val[rd_idx] : 14'h0;
            // R7 convert-start held high
            if (in_conv) chk(bus_convst_n, "R7 convst high", int'(bus_convst_n), 1);
            // R9 timeout pulse
            if (err) begin
                err_pulses++;
                chk(silent && in_conv && k == exp_to, "R9 err timing", k, exp_to);
            end
            // R8 end of cycle
            if (in_conv && !busy) begin
                in_conv = 1'b0;
                if (!silent) begin
                    chk(rd_idx == n_res, "R8 all read", rd_idx, n_res);
                    chk(q_data.size() == 0, "R8 all delivered", q_data.size(), 0);
                end
            end
            // R6 stream hold and no read while waiting
            if (p_valid && !p_ready)
                chk(m_valid && m_data == p_data && m_chan == p_chan, "R6 hold", int'(m_data), int'(p_data));
            if (m_valid) chk(bus_rd_n, "R6 no read on stall", int'(bus_rd_n), 1);
            // consumer ready for the coming edge
            case (ready_mode)
                1:       m_ready = (cyc % 3) != 0;
                2:       m_ready = ((cyc / 20) % 2) == 1;
                default: m_ready = 1'b1;
            endcase
            // R5 scoreboard
            if (m_valid && m_ready) begin
                if (q_data.size() == 0) begin
                    chk(1'b0, "R5 unexpected result", int'(m_data), -1);
                end else begin
                    chk(m_data == q_data[0], "R5 data", int'(m_data), int'(q_data[0]));
                    chk(int'(m_chan) == q_chan[0], "R5 channel", int'(m_chan), q_chan[0]);
                    void'(q_data.pop_front());
                    void'(q_chan.pop_front());
                end
            end
            p_valid = m_valid; p_ready = m_ready; p_data = m_data; p_chan = m_chan;
            p_wr = bus_wr_n; p_rd = bus_rd_n; p_cv = bus_convst_n;
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic run(input logic [7:0] mask, input int acq, input int stb,
                       input int to, input int mode, input bit quiet);
        int writes0, errs0, w;
        writes0 = n_cfg_writes;
        errs0   = err_pulses;
        @(negedge clk);
        cfg_mask = mask; cfg_acq = 16'(acq); cfg_strobe = 4'(stb); cfg_timeout = 20'(to);
        exp_mask = mask; exp_stb = (stb < 1) ? 1 : stb; exp_acq = (acq < 2) ? 2 : acq;
        exp_to = (to < 1) ? 1 : to; ready_mode = mode; silent = quiet;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cfg_mask = ~mask;                       // R10 change while busy
        repeat (4) @(negedge clk);
        start = 1'b1;                           // R10 ignored request
        @(negedge clk);
        start = 1'b0;
        w = 0;
        while (busy && w < 4000) begin
            @(negedge clk);
            w++;
        end
        repeat (3) @(negedge clk);
        chk(n_cfg_writes == writes0 + 1, "R10 single write", n_cfg_writes - writes0, 1);
        chk(latched == mask, "R2 latched mask", int'(latched), int'(mask));
        chk(err_pulses == errs0 + (quiet ? 1 : 0), "R9 err count", err_pulses - errs0, quiet ? 1 : 0);
        if (!quiet) chk(rd_idx == n_res && q_data.size() == 0, "R8 run complete", rd_idx, n_res);
        chk(!busy && !m_valid, "R8 idle after run", int'(busy), 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk(bus_cs_n && bus_wr_n && bus_rd_n && bus_convst_n, "R1 strobes in reset", int'(bus_cs_n), 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(bus_cs_n && bus_wr_n && bus_rd_n, "R1 cs/wr/rd idle", int'(bus_rd_n), 1);
        chk(bus_convst_n, "R1 convst idle", int'(bus_convst_n), 1);
        chk(!busy && !err && !m_valid, "R1 status idle", int'(busy), 0);
        run(8'hA6, 5, 2, 200, 0, 1'b0);         // sparse mask
        run(8'hFF, 0, 0, 200, 1, 1'b0);         // minimums, toggling ready
        run(8'h80, 1, 3, 200, 2, 1'b0);         // single top channel, long stalls
        run(8'h01, 3, 1, 200, 0, 1'b0);         // single bottom channel
        run(8'h3C, 10, 1, 200, 2, 1'b0);        // middle channels, stalls
        run(8'h0F, 4, 2, 25, 0, 1'b1);          // R9 timeout
        run(8'h0F, 2, 1, 0, 0, 1'b1);           // R9 minimum limit
        run(8'hC3, 2, 2, 200, 1, 1'b0);         // recovery after timeout
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule